// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Framing Error

This block receives asynchronous serial frames in the manner of a classic 8-bit controller's serial port. A frame is one start bit (0), then 8 or 9 data bits sent least-significant bit first, then one stop bit (1). The line is oversampled by an external 16x tick. A falling edge on the idle line opens a frame. Each bit is decided by a majority vote of three samples taken at the middle of the bit period.

A small control register selects the frame format and enables reception. It also holds the ninth received bit, a sticky receive-complete flag and a sticky framing-error flag. A separate input turns on stop-bit checking. While checking is on, one register bit position stops acting as a mode bit and carries the framing-error flag instead. Checking also moves the receive-complete event from the last data bit to the stop bit. Software polls the flags, reads the data buffer, and writes zeros to clear the flags.

Top module: `uart_rx_fe`

## Requirements
- R1: After reset, `ctl_rdata` reads 0 and `rx_data` reads 0.
- R2: In mode 1 (mode field `{ctl bit4, ctl bit3}` = 01), a frame of 8 data bits sent LSB first is stored in `rx_data`, the done flag (ctl bit 0) is set, and ctl bit 1 is left unchanged.
- R3: In modes 2 and 3 (mode field 10 or 11), a frame carries 9 data bits. The first 8 go to `rx_data` and the ninth goes to ctl bit 1.
- R4: Each bit value is the majority of three line samples at oversampling ticks 7, 8 and 9 of the bit. A disturbance lasting one tick in the middle of a data bit does not change the received value.
- R5: If the start bit samples as 1 at its middle, the frame is dropped. No flag is set, the data buffer is untouched, and the receiver waits for a new falling edge.
- R6: No frame is received while the enable field (ctl bit 2) is 0 or the mode field is 00. Flags and the buffer stay unchanged.
- R7: When `fe_chk_en` is 1 and the stop bit samples as 0, the framing-error flag is set. When `fe_chk_en` is 0, the flag is never set.
- R8: The framing-error flag stays set through later valid frames. It is cleared only by reset or by a write with ctl bit 4 = 0 while `fe_chk_en` is 1.
- R9: With `fe_chk_en` = 1, the done flag and the buffer update at the stop-bit decision. With `fe_chk_en` = 0, they update at the last data-bit decision.
- R10: The done flag is sticky. A write with ctl bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it unchanged.
- R11: Ctl bit 4 reads and writes the framing-error flag while `fe_chk_en` = 1. While `fe_chk_en` = 0 it reads and writes the upper mode bit. Each of the two stored values is untouched by accesses in the other setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| fe_chk_en | input | 1 | Enables stop-bit checking and selects the meaning of ctl bit 4 |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Write data: [4] mode-hi/FE, [3] mode-lo, [2] enable, [1] ninth bit, [0] done |
| ctl_rdata | output | 5 | Control register read value, same layout |
| rx_data | output | 8 | Received data buffer |

## Verification
The assertions check on every cycle that both flags are sticky under any stimulus, and that only a zero write clears them. They also check that a load happens at the stop decision exactly when checking is on, that a rejected start never loads, and that no load happens while reception is disabled. A further check is that a write made with checking on never disturbs the stored mode bit. Only the bench's scenarios can show the rest. That covers whether the bits land in the right positions LSB first and whether the ninth bit goes to its own field. It also covers the vote rejecting a one-tick disturbance, a short start pulse being dropped, and the done flag being visible part-way through the stop bit only when checking is off.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int DATA_W = 8;
  localparam int OSR    = 16;
  localparam int MID    = 8;
  localparam int CTL_W  = 5;

  localparam int CB_SHARED = 4;
  localparam int CB_MODELO = 3;
  localparam int CB_RXEN   = 2;
  localparam int CB_NINTH  = 1;
  localparam int CB_DONE   = 0;

  typedef enum logic [0:0] {RX_IDLE, RX_RUN} rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic int unsigned data_bits(input logic [1:0] mode);
    return (mode == 2'b01) ? DATA_W : DATA_W + 1;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], line_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign line_s = chain[STAGES-1];
  assign fall   = prev & ~chain[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int RATE = OSR,
  parameter int CTR  = MID
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_s,
  input  logic restart,
  input  logic active,
  output logic vote_valid,
  output logic vote
);
  localparam int CNT_W = $clog2(RATE);
  localparam logic [CNT_W-1:0] C_A    = CNT_W'(CTR - 1);
  localparam logic [CNT_W-1:0] C_B    = CNT_W'(CTR);
  localparam logic [CNT_W-1:0] C_C    = CNT_W'(CTR + 1);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(RATE - 1);

  logic [CNT_W-1:0] cnt;
  logic             s_a, s_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else if (restart) begin
      cnt <= '0;
    end else if (active && tick) begin
      cnt <= (cnt == C_LAST) ? '0 : cnt + 1'b1;
      if (cnt == C_A) s_a <= line_s;
      if (cnt == C_B) s_b <= line_s;
    end
  end

  assign vote_valid = active & tick & ~restart & (cnt == C_C);
  assign vote       = vote3(s_a, s_b, line_s);
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          allow,
  input  logic          fall,
  input  logic [1:0]    mode,
  input  logic          fe_chk_en,
  input  logic          vote_valid,
  input  logic          vote,
  output logic          restart,
  output logic          active,
  output logic          ev_glitch,
  output logic          ev_last_data,
  output logic          ev_stop_sample,
  output logic          ev_load,
  output logic          ev_fe_set,
  output logic [DW:0]   load_word
);
  localparam int IDX_W = $clog2(DW + 3);

  rx_state_e        state;
  logic [IDX_W-1:0] idx;
  logic [DW:0]      shreg;
  logic [IDX_W-1:0] nbits;
  logic             run_dec, ev_data;

  assign nbits   = IDX_W'(data_bits(mode));
  assign active  = (state == RX_RUN) & allow;
  assign restart = (state == RX_IDLE) & allow & fall;
  assign run_dec = active & vote_valid;

  assign ev_glitch      = run_dec & (idx == '0) & vote;
  assign ev_data        = run_dec & (idx != '0) & (idx <= nbits);
  assign ev_last_data   = ev_data & (idx == nbits);
  assign ev_stop_sample = run_dec & (idx == nbits + 1'b1);
  assign ev_load        = fe_chk_en ? ev_stop_sample : ev_last_data;
  assign ev_fe_set      = fe_chk_en & ev_stop_sample & ~vote;

  always_comb begin
    load_word = shreg;
    if (ev_data) load_word[idx - 1'b1] = vote;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      idx   <= '0;
      shreg <= '0;
    end else if (!allow) begin
      state <= RX_IDLE;
    end else if (restart) begin
      state <= RX_RUN;
      idx   <= '0;
      shreg <= '0;
    end else if (run_dec) begin
      shreg <= load_word;
      idx   <= idx + 1'b1;
      if (ev_glitch || ev_stop_sample) state <= RX_IDLE;
    end
  end
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             fe_chk_en,
  input  logic             ev_load,
  input  logic             ev_fe_set,
  input  logic [DW:0]      load_word,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic [DW-1:0]    rx_data,
  output logic [1:0]       mode,
  output logic             rx_en,
  output logic             mode_hi,
  output logic             fe_flag,
  output logic             done_flag
);
  logic mode_lo, ninth;

  assign mode = {mode_hi, mode_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_hi   <= 1'b0;
      mode_lo   <= 1'b0;
      rx_en     <= 1'b0;
      ninth     <= 1'b0;
      done_flag <= 1'b0;
      fe_flag   <= 1'b0;
      rx_data   <= '0;
    end else begin
      if (ctl_wr) begin
        mode_lo <= ctl_wdata[CB_MODELO];
        rx_en   <= ctl_wdata[CB_RXEN];
        if (!fe_chk_en) mode_hi <= ctl_wdata[CB_SHARED];
      end
      if (ev_load && data_bits(mode) > DW) ninth <= load_word[DW];
      else if (ctl_wr) ninth <= ctl_wdata[CB_NINTH];
      if (ev_load) done_flag <= 1'b1;
      else if (ctl_wr && !ctl_wdata[CB_DONE]) done_flag <= 1'b0;
      if (ev_fe_set) fe_flag <= 1'b1;
      else if (ctl_wr && fe_chk_en && !ctl_wdata[CB_SHARED]) fe_flag <= 1'b0;
      if (ev_load) rx_data <= load_word[DW-1:0];
    end
  end

  always_comb begin
    ctl_rdata            = '0;
    ctl_rdata[CB_SHARED] = fe_chk_en ? fe_flag : mode_hi;
    ctl_rdata[CB_MODELO] = mode_lo;
    ctl_rdata[CB_RXEN]   = rx_en;
    ctl_rdata[CB_NINTH]  = ninth;
    ctl_rdata[CB_DONE]   = done_flag;
  end
endmodule

// File: rtl/uart_rx_fe.sv
module uart_rx_fe
  import uart_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic             os_tick,
  input  logic             fe_chk_en,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic [DATA_W-1:0] rx_data
);
  logic            line_s, fall, restart, active, vote_valid, vote;
  logic            ev_glitch, ev_last_data, ev_stop_sample, ev_load, ev_fe_set;
  logic [DATA_W:0] load_word;
  logic [1:0]      mode;
  logic            rx_en, mode_hi, fe_flag, done_flag, allow;

  assign allow = rx_en & (mode != 2'b00);

  uart_rx_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .line_in(rx_line), .line_s(line_s), .fall(fall)
  );

  uart_rx_sampler #(.RATE(OSR), .CTR(MID)) i_sampler (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line_s(line_s),
    .restart(restart), .active(active), .vote_valid(vote_valid), .vote(vote)
  );

  uart_rx_fsm #(.DW(DATA_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .allow(allow), .fall(fall), .mode(mode),
    .fe_chk_en(fe_chk_en), .vote_valid(vote_valid), .vote(vote),
    .restart(restart), .active(active), .ev_glitch(ev_glitch),
    .ev_last_data(ev_last_data), .ev_stop_sample(ev_stop_sample),
    .ev_load(ev_load), .ev_fe_set(ev_fe_set), .load_word(load_word)
  );

  uart_rx_regs #(.DW(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .fe_chk_en(fe_chk_en), .ev_load(ev_load), .ev_fe_set(ev_fe_set),
    .load_word(load_word), .ctl_rdata(ctl_rdata), .rx_data(rx_data),
    .mode(mode), .rx_en(rx_en), .mode_hi(mode_hi), .fe_flag(fe_flag),
    .done_flag(done_flag)
  );
endmodule

// File: rtl/uart_rx_fe_chk.sv
module uart_rx_fe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fe_chk_en,
  input logic       ctl_wr,
  input logic [4:0] ctl_wdata,
  input logic       ev_glitch,
  input logic       ev_stop_sample,
  input logic       ev_load,
  input logic       ev_fe_set,
  input logic       fe_flag,
  input logic       done_flag,
  input logic       mode_hi,
  input logic       rx_en,
  input logic [1:0] mode
);
  // R8
  fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_flag && !(ctl_wr && fe_chk_en && !ctl_wdata[4])) |=> fe_flag);

  // R7
  fe_only_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_flag && !ev_fe_set) |=> !fe_flag);

  // R7
  fe_set_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fe_set |-> (fe_chk_en && ev_stop_sample));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !(ctl_wr && !ctl_wdata[0])) |=> done_flag);

  // R9
  load_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |-> (fe_chk_en == ev_stop_sample));

  // R9
  load_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> done_flag);

  // R5
  glitch_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_glitch |-> !ev_load);

  // R6
  load_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |-> (rx_en && mode != 2'b00));

  // R11
  mode_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && fe_chk_en) |=> $stable(mode_hi));
endmodule

bind uart_rx_fe uart_rx_fe_chk i_uart_rx_fe_chk (
  .clk(clk), .rst_n(rst_n), .fe_chk_en(fe_chk_en), .ctl_wr(ctl_wr),
  .ctl_wdata(ctl_wdata), .ev_glitch(ev_glitch), .ev_stop_sample(ev_stop_sample),
  .ev_load(ev_load), .ev_fe_set(ev_fe_set), .fe_flag(fe_flag),
  .done_flag(done_flag), .mode_hi(mode_hi), .rx_en(rx_en), .mode(mode)
);

// File: tb/test_uart_rx_fe.sv
`timescale 1ns/1ps
module test_uart_rx_fe;
  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       os_tick = 1'b0;
  logic       fe_chk_en = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic [4:0] ctl_rdata;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [1:0] tick_div = '0;

  logic [1:0] cur_mode = 2'b00;
  logic       exp_fe = 1'b0, exp_ninth = 1'b0;
  logic [7:0] exp_data = '0;
  logic       mid_done;
  logic [7:0] mid_data;

  uart_rx_fe i_uart_rx_fe (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .fe_chk_en(fe_chk_en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .rx_data(rx_data)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tick_div <= tick_div + 1'b1;
    os_tick  <= (tick_div == 2'd3);
  end

  function automatic int nbits_of(input logic [1:0] m);
    return (m == 2'b01) ? 8 : 9;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] v);
    @(posedge clk); #1; ctl_wr = 1'b1; ctl_wdata = v;
    @(posedge clk); #1; ctl_wr = 1'b0;
  endtask

  // Writes the mode with checking off, clears done, then sets the checking input.
  task automatic setup(input logic [1:0] m, input logic en, input logic fe);
    fe_chk_en = 1'b0;
    wr({m[1], m[0], en, exp_ninth, 1'b0});
    cur_mode = m;
    fe_chk_en = fe;
    @(posedge clk); #1;
  endtask

  task automatic drive_bit(input logic v, input bit glitch, input bit probe);
    for (int c = 0; c < BITCLK; c++) begin
      @(posedge clk); #1;
      rx_line = (glitch && c >= 30 && c < 34) ? ~v : v;
      if (probe && c == 8) begin
        mid_done = ctl_rdata[0];
        mid_data = rx_data;
      end
    end
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic stopv, input int gbit);
    drive_bit(1'b0, 0, 0);
    for (int i = 0; i < nb; i++) drive_bit(d[i], gbit == i, 0);
    drive_bit(stopv, 0, 1);
    drive_bit(1'b1, 0, 0);
    drive_bit(1'b1, 0, 0);
  endtask

  // Sends one frame and checks it against the bench model.
  task automatic frame(input logic [8:0] d, input logic stopv, input int gbit);
    int nb;
    logic [7:0] prev;
    nb = nbits_of(cur_mode);
    prev = exp_data;
    send(d, nb, stopv, gbit);
    exp_data = d[7:0];
    if (nb == 9) exp_ninth = d[8];
    if (fe_chk_en && !stopv) exp_fe = 1'b1;
    // R9: done and buffer visible early in the stop bit only when checking is off
    check("R9 done mid stop", mid_done, fe_chk_en ? 0 : 1);
    check("R9 buffer mid stop", mid_data, fe_chk_en ? prev : exp_data);
    // R2 R3 R4: data LSB first, ninth bit, vote
    check(nb == 9 ? "R3 data" : "R2 data", rx_data, exp_data);
    check(nb == 9 ? "R3 ninth" : "R2 ninth kept", ctl_rdata[1], exp_ninth);
    check("R10 done set", ctl_rdata[0], 1);
    // R7 R8 R11: shared bit
    check(fe_chk_en ? "R8 fe flag" : "R11 mode hi", ctl_rdata[4],
          fe_chk_en ? exp_fe : cur_mode[1]);
  endtask

  initial begin
    void'($urandom(32'h5eed_0123));
    repeat (5) @(posedge clk);
    #1;
    check("R1 ctl reset", ctl_rdata, 0);
    check("R1 data reset", rx_data, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;

    // R2 mode 1
    setup(2'b01, 1, 0);
    frame(9'h0A5, 1'b1, -1);
    setup(2'b01, 1, 0);
    frame(9'h13C, 1'b1, -1);

    // R3 mode 2 and 3 with ninth bit
    setup(2'b10, 1, 0);
    frame(9'h1C3, 1'b1, -1);
    setup(2'b11, 1, 1);
    frame(9'h05A, 1'b1, -1);

    // R4 one-tick disturbance in data bit 3
    setup(2'b01, 1, 0);
    frame(9'h0F0, 1'b1, 3);

    // R7 stop 0 with checking off: no FE
    setup(2'b01, 1, 0);
    frame(9'h081, 1'b0, -1);
    fe_chk_en = 1'b1; @(posedge clk); #1;
    check("R7 no fe when off", ctl_rdata[4], 0);

    // R7 stop 0 with checking on
    setup(2'b11, 1, 1);
    frame(9'h17E, 1'b0, -1);
    check("R7 fe set", ctl_rdata[4], 1);
    // R8 later valid frame keeps FE
    setup(2'b11, 1, 1);
    wr({1'b1, 1'b1, 1'b1, exp_ninth, 1'b0});
    frame(9'h011, 1'b1, -1);
    check("R8 fe kept", ctl_rdata[4], 1);

    // R11 FE hidden while off; mode hi visible
    fe_chk_en = 1'b0; @(posedge clk); #1;
    check("R11 mode visible", ctl_rdata[4], 1);
    wr({1'b0, 1'b1, 1'b1, exp_ninth, 1'b1});
    cur_mode = 2'b01;
    check("R11 mode written", ctl_rdata[4], 0);
    fe_chk_en = 1'b1; @(posedge clk); #1;
    check("R11 fe untouched", ctl_rdata[4], 1);
    // R8 clear FE; R11 mode untouched
    wr({1'b0, 1'b1, 1'b1, exp_ninth, 1'b1});
    exp_fe = 1'b0;
    check("R8 fe cleared", ctl_rdata[4], 0);
    wr({1'b1, 1'b1, 1'b1, exp_ninth, 1'b1});
    check("R8 write one no set", ctl_rdata[4], 0);
    fe_chk_en = 1'b0; @(posedge clk); #1;
    check("R11 mode unchanged", ctl_rdata[4], 0);

    // R10 done write one keeps, write zero clears
    check("R10 done still set", ctl_rdata[0], 1);
    wr({1'b0, 1'b1, 1'b1, exp_ninth, 1'b0});
    check("R10 done cleared", ctl_rdata[0], 0);

    // R5 short start pulse
    for (int c = 0; c < 12; c++) begin @(posedge clk); #1; rx_line = 1'b0; end
    for (int c = 0; c < 12 * BITCLK; c++) begin @(posedge clk); #1; rx_line = 1'b1; end
    check("R5 no done", ctl_rdata[0], 0);
    check("R5 data kept", rx_data, exp_data);
    frame(9'h066, 1'b1, -1);

    // R6 disabled and mode 0
    setup(2'b01, 0, 0);
    send(9'h0FF, 8, 1'b1, -1);
    check("R6 off no done", ctl_rdata[0], 0);
    check("R6 off data kept", rx_data, exp_data);
    setup(2'b00, 1, 0);
    send(9'h1AA, 9, 1'b1, -1);
    check("R6 mode0 no done", ctl_rdata[0], 0);
    check("R6 mode0 data kept", rx_data, exp_data);

    // Random frames
    for (int k = 0; k < 30; k++) begin
      logic [1:0] m;
      logic fe, st;
      int g;
      m  = 2'($urandom_range(1, 3));
      fe = 1'($urandom % 2);
      st = ($urandom % 4) != 0;
      g  = ($urandom % 3 == 0) ? int'($urandom % 8) : -1;
      setup(m, 1, fe);
      frame(9'($urandom), st, g);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule